// File: doc/BRIEF.md
# Masked-Write Ring-Oscillator Random Number Controller

This block is a memory-mapped random number generator controller. Software programs a sample interval, then writes a control word that picks how many bits to produce (64, 128, 192 or 256) and which of four entropy rings to draw from. It then sets the enable and start bits and polls until start drops back to zero. The collected bits are then readable as up to eight 32-bit words.

The control register takes masked writes: the upper half of each write word is a per-bit write enable for the lower half, so software can change one field without a read-modify-write. The entropy source is a 32-bit linear feedback shift register that advances once per sample. The ring selection stretches the sample interval by a power of two, standing in for slower oscillators.

Reads use a request/valid handshake. A read request is answered one clock later with registered data.

Top module: `rosc_rng`

## Requirements
- R1: After synchronous reset the control register reads 0x00000000, the sample-count register reads 100 (0x64), every output word reads zero and the read-valid output is low.
- R2: A write to the control register (byte address 0x00) changes control bit k (k = 0..5) only when write-data bit 16+k is 1; bits whose mask bit is 0 keep their value.
- R3: The control register reads back as its six bits in positions 5:0, with the upper bits zero. The fields are: length code in bits 5:4, ring code in bits 3:2, enable in bit 1 and start in bit 0.
- R4: If a write leaves enable at 0, start reads 0 afterwards and no generation begins, whatever value was written to the start bit.
- R5: When start goes from 0 to 1 with enable set, generation runs for exactly P*N clocks and start then clears itself. N = 64*(length code+1). P = S*2^(ring code), where S is the sample count, or 1 when S is zero.
- R6: The sample-count register sits at byte address 0x04, holds 16 bits and reads back as written. The value present at the start edge is the one a run uses.
- R7: Entropy bits come from a 32-bit Galois register, seeded to 1 at reset, with feedback mask 0xA3000000. Each sample takes bit 0 of the state, then shifts the state right by one and XORs in the mask if the taken bit was 1. The state carries over from one run to the next.
- R8: Sample number b (counting from 0) is stored in output word b/32, at bit position 31-(b mod 32). Output word i is read at byte address 0x10+4*i.
- R9: A start clears all eight words. Words beyond N/32 stay zero, and all words keep their values after the run until the next start.
- R10: A control write of 0xFFFF0000 stops a run in progress. Start reads 0 the next cycle, and the words keep the bits collected so far.
- R11: A read request is answered with read-valid high exactly one clock later, carrying the register value from the request cycle. Read-valid is low in every other cycle, and unmapped or misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one clock after bus_re |

## Verification
Runs are started with every length code and every ring code, with sample counts of 0, 1, 2, 3 and 100. Each run's busy interval is measured by polling. This separates a wrong ring multiplier from a wrong length decode, and it exposes zero-count handling. Reading all eight words after runs of different lengths shows whether bits land in the wrong position or spill past the selected length. Because the entropy state carries over, consecutive runs also show whether bits are lost between runs. Partial-mask writes, start without enable, and a mid-run full-mask stop check that the control update keeps unmasked fields and keeps partial data.

// File: rtl/rosc_rng_pkg.sv
package rosc_rng_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 8;
    localparam int MAX_BITS   = NUM_WORDS * WORD_W;
    localparam int BIT_IDX_W  = $clog2(MAX_BITS);
    localparam int POS_W      = $clog2(WORD_W);
    localparam int WORD_IDX_W = $clog2(NUM_WORDS);
    localparam int CTRL_W     = 6;
    localparam int MASK_LSB   = 16;
    localparam int BITS_PER_LEN_STEP = 64;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SCNT  = 8'h04;
    localparam logic [7:0] OFS_DATA0 = 8'h10;

    typedef enum logic [1:0] {
        RING_FASTEST = 2'd0,
        RING_FAST    = 2'd1,
        RING_SLOW    = 2'd2,
        RING_SLOWEST = 2'd3
    } ring_e;

    typedef struct packed {
        logic [1:0] len;
        ring_e      ring;
        logic       en;
        logic       go;
    } ctrl_t;

    // Apply a write whose upper half is a per-bit enable for the lower half.
    function automatic ctrl_t masked_update(ctrl_t cur, logic [31:0] wd);
        logic [CTRL_W-1:0] c;
        c = cur;
        for (int k = 0; k < CTRL_W; k++) begin
            if (wd[MASK_LSB + k]) c[k] = wd[k];
        end
        return ctrl_t'(c);
    endfunction

    // Index of the final sample for a length code.
    function automatic logic [BIT_IDX_W-1:0] last_sample_idx(logic [1:0] len);
        return BIT_IDX_W'((int'(len) + 1) * BITS_PER_LEN_STEP - 1);
    endfunction

endpackage

// File: rtl/rosc_rng_lfsr.sv
module rosc_rng_lfsr #(
    parameter int          W     = 32,
    parameter logic [W-1:0] TAPS = 32'hA300_0000,
    parameter logic [W-1:0] SEED = 32'h0000_0001
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic bit_out
);
    logic [W-1:0] state_q;

    assign bit_out = state_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end
endmodule

// File: rtl/rosc_rng_seq.sv
module rosc_rng_seq
    import rosc_rng_pkg::*;
#(
    parameter int SC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ctrl,
    input  logic [31:0]          wdata,
    input  logic [SC_W-1:0]      sample_cnt,
    output ctrl_t                ctrl_q,
    output logic                 launch,
    output logic                 tick,
    output logic [BIT_IDX_W-1:0] bit_idx
);
    localparam int PER_W = SC_W + 3;

    logic [PER_W-1:0]     per_cnt_q;
    logic [PER_W-1:0]     per_reload_q;
    logic [BIT_IDX_W-1:0] last_idx_q;
    logic [BIT_IDX_W-1:0] bit_idx_q;

    ctrl_t            base;
    ctrl_t            nxt;
    logic             done;
    logic [SC_W-1:0]  sc_eff;
    logic [PER_W-1:0] period_m1;

    assign tick    = ctrl_q.go && (per_cnt_q == '0);
    assign done    = tick && (bit_idx_q == last_idx_q);
    assign bit_idx = bit_idx_q;

    always_comb begin
        base = ctrl_q;
        if (done) base.go = 1'b0;
        nxt = wr_ctrl ? masked_update(base, wdata) : base;
        if (!nxt.en) nxt.go = 1'b0;
        launch = nxt.go && !base.go;
    end

    always_comb begin
        sc_eff    = (sample_cnt == '0) ? SC_W'(1) : sample_cnt;
        period_m1 = (PER_W'(sc_eff) << nxt.ring) - PER_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            per_cnt_q    <= '0;
            per_reload_q <= '0;
            last_idx_q   <= '0;
            bit_idx_q    <= '0;
        end else begin
            ctrl_q <= nxt;
            if (launch) begin
                per_cnt_q    <= period_m1;
                per_reload_q <= period_m1;
                last_idx_q   <= last_sample_idx(nxt.len);
                bit_idx_q    <= '0;
            end else if (tick) begin
                per_cnt_q <= per_reload_q;
                bit_idx_q <= bit_idx_q + BIT_IDX_W'(1);
            end else if (ctrl_q.go) begin
                per_cnt_q <= per_cnt_q - PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/rosc_rng_bank.sv
module rosc_rng_bank
    import rosc_rng_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 clear,
    input  logic                                 tick,
    input  logic                                 bit_in,
    input  logic [BIT_IDX_W-1:0]                 bit_idx,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]     words
);
    logic [WORD_IDX_W-1:0] sel_word;
    logic [POS_W-1:0]      sel_pos;

    assign sel_word = bit_idx[BIT_IDX_W-1:POS_W];
    assign sel_pos  = ~bit_idx[POS_W-1:0];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word_q <= '0;
            end else if (tick && (sel_word == WORD_IDX_W'(w))) begin
                word_q[sel_pos] <= bit_in;
            end
        end

        assign words[w] = word_q;
    end
endmodule

// File: rtl/rosc_rng.sv
module rosc_rng
    import rosc_rng_pkg::*;
#(
    parameter int          SC_W      = 16,
    parameter int          SC_RESET  = 100,
    parameter logic [31:0] LFSR_SEED = 32'h0000_0001,
    parameter logic [31:0] LFSR_TAPS = 32'hA300_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    input  logic        bus_re,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid
);
    localparam int DATA_SPAN = NUM_WORDS * 4;

    ctrl_t                           ctrl_q;
    logic [SC_W-1:0]                 sample_cnt_q;
    logic                            launch;
    logic                            tick;
    logic                            ent_bit;
    logic [BIT_IDX_W-1:0]            bit_idx;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                            wr_ctrl;
    logic [7:0]                      data_ofs;
    logic [31:0]                     rd_mux;
    logic [31:0]                     rdata_q;
    logic                            rvalid_q;

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);

    rosc_rng_seq #(.SC_W(SC_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wdata      (bus_wdata),
        .sample_cnt (sample_cnt_q),
        .ctrl_q     (ctrl_q),
        .launch     (launch),
        .tick       (tick),
        .bit_idx    (bit_idx)
    );

    rosc_rng_lfsr #(.W(32), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_src (
        .clk     (clk),
        .rst     (rst),
        .step    (tick),
        .bit_out (ent_bit)
    );

    rosc_rng_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .tick    (tick),
        .bit_in  (ent_bit),
        .bit_idx (bit_idx),
        .words   (words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_cnt_q <= SC_W'(SC_RESET);
        end else if (bus_we && (bus_addr == OFS_SCNT)) begin
            sample_cnt_q <= bus_wdata[SC_W-1:0];
        end
    end

    assign data_ofs = bus_addr - OFS_DATA0;

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_CTRL) begin
            rd_mux = 32'(ctrl_q);
        end else if (bus_addr == OFS_SCNT) begin
            rd_mux = 32'(sample_cnt_q);
        end else if ((int'(data_ofs) < DATA_SPAN) && (data_ofs[1:0] == 2'b00)) begin
            rd_mux = words[data_ofs[2 +: WORD_IDX_W]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_re;
            if (bus_re) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/rosc_rng_checker.sv
module rosc_rng_checker #(
    parameter int SC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      bus_addr,
    input logic            bus_we,
    input logic [31:0]     bus_wdata,
    input logic            bus_re,
    input logic            bus_rvalid,
    input logic [5:0]      ctrl_bits,
    input logic [SC_W-1:0] sample_cnt,
    input logic [255:0]    words_flat
);
    logic wr_ctrl;
    assign wr_ctrl = bus_we && (bus_addr == 8'h00);

    // R11: a request is answered one clock later
    a_r11_rvalid_follows_re: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> bus_rvalid);

    // R11: no response without a request
    a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> !bus_rvalid);

    // R4: start cannot be set while enable stays clear
    a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[16] && bus_wdata[0] && !ctrl_bits[1]
         && !(bus_wdata[17] && bus_wdata[1])) |=> !ctrl_bits[0]);

    // R2: length field untouched when its mask bits are clear
    a_r2_unmasked_len_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (bus_wdata[21:20] == 2'b00)) |=> $stable(ctrl_bits[5:4]));

    // R10: full-mask zero write stops everything
    a_r10_full_mask_stop: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (bus_wdata == 32'hFFFF_0000)) |=> (ctrl_bits == 6'd0));

    // R9: words hold while idle unless a new run starts
    a_r9_words_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !ctrl_bits[0] |=> (ctrl_bits[0] || $stable(words_flat)));

    // R6: sample-count register takes the written value
    a_r6_scnt_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == 8'h04)) |=> (sample_cnt == $past(bus_wdata[SC_W-1:0])));
endmodule

bind rosc_rng rosc_rng_checker #(.SC_W(SC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_re     (bus_re),
    .bus_rvalid (bus_rvalid),
    .ctrl_bits  (ctrl_q),
    .sample_cnt (sample_cnt_q),
    .words_flat (words)
);

// File: tb/test_rosc_rng.sv
`timescale 1ns/1ps
module test_rosc_rng;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    rosc_rng i_rosc_rng (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    // ---------------- reference model ----------------
    logic [5:0]  m_ctrl;
    logic [15:0] m_sc;
    logic [31:0] m_words [8];
    logic [31:0] m_lfsr;
    int          m_el, m_P, m_n;
    bit          exp_valid;
    logic [31:0] exp_data;
    string       exp_tag;

    function automatic logic [31:0] model_read(logic [7:0] a);
        int ofs;
        ofs = int'(a) - 16;
        if (a == 8'h00) return {26'd0, m_ctrl};
        if (a == 8'h04) return {16'd0, m_sc};
        if (ofs >= 0 && ofs < 32 && (ofs % 4) == 0) return m_words[ofs / 4];
        return 32'd0;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a == 8'h00) return "R5";
        if (a == 8'h04) return "R6";
        if (a >= 8'h10 && a < 8'h30 && a[1:0] == 2'b00) return "R8";
        return "R11";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_sc = 16'd100; m_lfsr = 32'h1;
            for (int i = 0; i < 8; i++) m_words[i] = '0;
            m_el = 0; m_P = 1; m_n = 64;
            exp_valid = 1'b0; exp_data = '0; exp_tag = "R1";
        end else begin
            logic [5:0] base;
            logic [5:0] nxt;
            exp_valid = bus_re;
            if (bus_re) begin
                exp_data = model_read(bus_addr);
                exp_tag  = tag_of(bus_addr);
            end
            base = m_ctrl;
            if (base[0]) begin
                m_el++;
                if (m_el % m_P == 0) begin
                    int  b;
                    bit  sb;
                    b  = m_el / m_P - 1;
                    sb = m_lfsr[0];
                    m_lfsr = (m_lfsr >> 1) ^ (sb ? 32'hA300_0000 : 32'h0);
                    m_words[b / 32][31 - (b % 32)] = sb;
                    if (b == m_n - 1) base[0] = 1'b0;
                end
            end
            nxt = base;
            if (bus_we && bus_addr == 8'h00) begin
                for (int k = 0; k < 6; k++) if (bus_wdata[16 + k]) nxt[k] = bus_wdata[k];
            end
            if (!nxt[1]) nxt[0] = 1'b0;
            if (nxt[0] && !base[0]) begin
                m_el = 0;
                m_P  = ((m_sc == 0) ? 1 : int'(m_sc)) << nxt[3:2];
                m_n  = 64 * (int'(nxt[5:4]) + 1);
                for (int i = 0; i < 8; i++) m_words[i] = '0;
            end
            m_ctrl = nxt;
            if (bus_we && bus_addr == 8'h04) m_sc = bus_wdata[15:0];
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (bus_rvalid !== exp_valid) begin
                n_bad++;
                $display("FAIL R11 rvalid: actual %0b expected %0b", bus_rvalid, exp_valid);
            end
            if (exp_valid) begin
                n_cmp++;
                if (bus_rdata !== exp_data) begin
                    n_bad++;
                    $display("FAIL %s read data: actual %08h expected %08h", exp_tag, bus_rdata, exp_data);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poll(output int busy);
        logic [31:0] d;
        busy = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h00, d);
            if (!d[0]) break;
            busy++;
        end
    endtask

    task automatic check_words(int nbits);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(8'h10 + 8'(4 * i), d);
            if (i < nbits / 32) check("R7", "entropy word", d, m_words[i]);
            else                check("R9", "word beyond length", d, 32'd0);
        end
    endtask

    task automatic run(logic [15:0] sc, logic [5:0] cval, int exp_busy, string tag);
        int busy;
        logic [31:0] d;
        wr(8'h04, {16'd0, sc});
        wr(8'h00, {16'h003F, 10'd0, cval});
        poll(busy);
        check(tag, "busy cycles", 32'(busy), 32'(exp_busy));
        rd(8'h00, d);
        check("R3", "control readback after run", d, {26'd0, cval & 6'h3E});
        check_words(64 * (int'(cval[5:4]) + 1));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, keep;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "rvalid idle", {31'd0, bus_rvalid}, 32'd0);
        rd(8'h00, d); check("R1", "control reset", d, 32'd0);
        rd(8'h04, d); check("R1", "sample count reset", d, 32'd100);
        rd(8'h10, d); check("R1", "word0 reset", d, 32'd0);
        rd(8'h2C, d); check("R1", "word7 reset", d, 32'd0);

        // R4 start without enable
        wr(8'h00, 32'h0001_0001);
        rd(8'h00, d); check("R4", "start alone", d, 32'd0);
        wr(8'h00, 32'h0003_0001);
        rd(8'h00, d); check("R4", "start with enable cleared", d, 32'd0);
        rd(8'h10, d); check("R4", "no generation word0", d, 32'd0);

        // R2 masked writes
        wr(8'h00, 32'h0002_0002);
        rd(8'h00, d); check("R2", "enable only", d, 32'h02);
        wr(8'h00, 32'h0000_003F);
        rd(8'h00, d); check("R2", "no mask bits", d, 32'h02);
        wr(8'h00, 32'h0030_0010);
        rd(8'h00, d); check("R2", "length field only", d, 32'h12);
        wr(8'h00, 32'h000C_0008);
        rd(8'h00, d); check("R3", "ring field", d, 32'h1A);
        wr(8'h00, 32'hFFFF_0000);
        rd(8'h00, d); check("R10", "full mask clear", d, 32'h0);

        // R11 unmapped and misaligned reads
        rd(8'h08, d); check("R11", "unmapped 0x08", d, 32'd0);
        rd(8'h30, d); check("R11", "past data 0x30", d, 32'd0);
        rd(8'h11, d); check("R11", "misaligned 0x11", d, 32'd0);

        // R5 timing across lengths and rings, R7/R8/R9 contents
        run(16'd2, 6'h03, 2 * 64, "R5");     // len0 ring0
        rd(8'h10, keep);
        idle(50);
        rd(8'h10, d); check("R9", "word0 held after run", d, keep);
        run(16'd3, 6'h3B, 12 * 256, "R5");   // len3 ring2
        run(16'd1, 6'h1F, 8 * 128, "R5");    // len1 ring3
        run(16'd0, 6'h27, 2 * 192, "R6");    // len2 ring1, zero count acts as 1
        rd(8'h04, d); check("R6", "sample count readback", d, 32'd0);

        // R10 stop mid-run keeps partial words
        wr(8'h04, 32'd100);
        wr(8'h00, 32'h003F_003F);            // P = 800
        idle(1700);
        wr(8'h00, 32'hFFFF_0000);
        rd(8'h00, d); check("R10", "stopped control", d, 32'd0);
        rd(8'h10, keep); check("R10", "partial word0", keep, m_words[0]);
        idle(1000);
        rd(8'h10, d); check("R10", "partial word0 frozen", d, keep);
        rd(8'h14, d); check("R10", "word1 untouched", d, 32'd0);

        idle(4);
        finish_run();
    end
endmodule